// File: doc/BRIEF.md
# Byte Handshake Shift Link

This block carries one byte at a time between a host and a power-management microcontroller over a synchronous serial shift path. A pair of active-low lines paces every byte. The host raises a request line, and the microcontroller answers on an acknowledge line. The microcontroller supplies the shift clock. The host side of the link is the block itself.

An upper sequencer asks for a single byte move. It pulses `start` while the link is idle, and `dir` says whether a byte goes out or comes in. The block sets the shift direction first. It then loads the outgoing byte, or clears the shift register for an incoming one, and asserts the request on the next clock. After eight external clock rises it releases the request. It then waits, for a bounded number of cycles, for the acknowledge line to go back high. When the wait ends it reports `done`, together with the received byte and two status flags. One flag says the acknowledge never returned. The other says the acknowledge was already high when the shift finished.

The external clock, the serial data input and the acknowledge line all pass through a synchronizer of `SYNC_STAGES` flops. The latencies below assume the default of 2 stages.

Top module: `hs_shift_link`

## Requirements
- R1: After reset, `reqN` is 1, `shiftOutEn` is 0, and `done`, `busy`, `timeoutErr` and `ackEarlyWarn` are 0. `rxByte` is 0.
- R2: A `start` pulse while idle takes effect on the next rising `clk` edge. On that edge the direction (`shiftOutEn` = not `dir`) and the shift register load are applied, `busy` goes to 1 and `reqN` stays 1. One edge later `reqN` falls to 0. `dir` = 1 means receive and `dir` = 0 means transmit.
- R3: In transmit, `shiftDataOut` shows bit 7 of `txByte` first. After each falling `shiftClk` edge it shows the next lower bit, so the byte goes out MSB first. `shiftOutEn` returns to 0 when the request is released.
- R4: In receive, `shiftOutEn` is 0 and `shiftDataOut` holds 1. `shiftDataIn` is sampled on each rising `shiftClk` edge, MSB first. `rxByte` takes the assembled byte on the same clock edge that releases the request. A transmit leaves `rxByte` unchanged.
- R5: The eighth rising `shiftClk` edge ends the shift phase. `reqN` returns to 1 three `clk` edges after that edge reaches the input.
- R6: With the request released, `done` goes high three `clk` edges after `ackN` rises.
- R7: If `ackN` is still low `ACK_TIMEOUT` edges after the edge that released `reqN`, `done` pulses with `timeoutErr` = 1 on that edge. `timeoutErr` then holds until the next accepted `start`.
- R8: If `ackN` is already high when the shift phase ends, `ackEarlyWarn` is set and the transfer still completes. `done` follows one edge later. `ackEarlyWarn` holds until the next accepted `start`.
- R9: A `start` while `busy` is 1 is ignored. The direction, the byte being moved and the result do not change.
- R10: `shiftClk` edges while idle move nothing. `reqN`, `busy`, `shiftDataOut` and `rxByte` do not change.
- R11: `done` is high for exactly one `clk` cycle per transfer, and `busy` is 0 from the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one byte move (only taken when idle) |
| dir | input | 1 | 1 = receive a byte, 0 = transmit `txByte` |
| txByte | input | BYTE_BITS | Byte to transmit |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| rxByte | output | BYTE_BITS | Last received byte |
| timeoutErr | output | 1 | Acknowledge did not return within the bound |
| ackEarlyWarn | output | 1 | Acknowledge was already high at shift end |
| shiftClk | input | 1 | Shift clock from the microcontroller |
| shiftDataIn | input | 1 | Serial data from the microcontroller |
| shiftDataOut | output | 1 | Serial data to the microcontroller (1 when not driving) |
| shiftOutEn | output | 1 | 1 while the host drives the serial data line |
| reqN | output | 1 | Active-low transfer request |
| ackN | input | 1 | Active-low transfer acknowledge |

## Verification
The assertions rely on several conditions at the inputs. The microcontroller clock must be slow compared with `clk`, so that every `shiftClk` level lasts longer than the synchronizer delay and no edge is lost. `shiftDataIn` must be stable around each rising edge. `ackN` may change only while the request is in a defined state. The bench models the microcontroller with `shiftClk` levels five system cycles long. It changes data only while the clock is low, and it moves `ackN` only after `reqN` falls or rises. The bench sweeps every byte value in both directions and adds the timeout, early-acknowledge, busy-start and idle-clock cases.

// File: rtl/hslink_pkg.sv
package hslink_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic setup;     // apply direction and load/clear the shifter
    logic dirRx;     // direction applied on setup (1 = receive)
    logic shiftIn;   // shift one sampled bit in
    logic shiftOut;  // advance the outgoing bit
    logic countBit;  // one more bit moved
    logic capture;   // latch the received byte
    logic endShift;  // shift phase over, stop driving the line
  } linkCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic clkRise;
    logic clkFall;
    logic ackHigh;
    logic lastBit;
  } linkEvt_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_WAITACK
  } linkState_t;

endpackage

// File: rtl/hslink_sync.sv
module hslink_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hslink_datapath.sv
module hslink_datapath
  import hslink_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  linkCmd_t             cmd,
  input  logic [BYTE_BITS-1:0] txByte,
  input  logic                 shiftClk,
  input  logic                 shiftDataIn,
  input  logic                 ackN,
  output linkEvt_t             evt,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 shiftDataOut,
  output logic                 shiftOutEn
);

  localparam int CW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BYTE_BITS - 1);

  logic [2:0] rawIn, syncIn;
  logic clkS, dataS, ackS, clkPrev;
  logic [BYTE_BITS-1:0] shifter;
  logic [CW-1:0] bitCnt;

  assign rawIn = {shiftClk, shiftDataIn, ackN};

  hslink_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rawIn),
    .dout (syncIn)
  );

  assign clkS  = syncIn[2];
  assign dataS = syncIn[1];
  assign ackS  = syncIn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clkPrev <= 1'b0;
    else        clkPrev <= clkS;
  end

  assign evt.clkRise = clkS & ~clkPrev;
  assign evt.clkFall = ~clkS & clkPrev;
  assign evt.ackHigh = ackS;
  assign evt.lastBit = (bitCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifter    <= '0;
      bitCnt     <= '0;
      shiftOutEn <= 1'b0;
      rxByte     <= '0;
    end else if (cmd.setup) begin
      shifter    <= cmd.dirRx ? '0 : txByte;
      bitCnt     <= '0;
      shiftOutEn <= ~cmd.dirRx;
    end else begin
      if (cmd.shiftIn)  shifter <= {shifter[BYTE_BITS-2:0], dataS};
      if (cmd.shiftOut) shifter <= {shifter[BYTE_BITS-2:0], 1'b0};
      if (cmd.countBit) bitCnt  <= bitCnt + 1'b1;
      if (cmd.capture)  rxByte  <= {shifter[BYTE_BITS-2:0], dataS};
      if (cmd.endShift) shiftOutEn <= 1'b0;
    end
  end

  assign shiftDataOut = shiftOutEn ? shifter[BYTE_BITS-1] : 1'b1;

  AST_DIR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.setup || cmd.endShift) |=> $stable(shiftOutEn)); // R9

  AST_RX_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !shiftOutEn |-> shiftDataOut); // R4

  AST_NO_SHIFT_BOTH_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.shiftIn && cmd.shiftOut)); // R3

endmodule

// File: rtl/hslink_ctrl.sv
module hslink_ctrl
  import hslink_pkg::*;
#(
  parameter int ACK_TIMEOUT = 1600000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     dir,
  input  linkEvt_t evt,
  output linkCmd_t cmd,
  output logic     reqN,
  output logic     done,
  output logic     busy,
  output logic     timeoutErr,
  output logic     ackEarlyWarn
);

  localparam int TW = $clog2(ACK_TIMEOUT + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(ACK_TIMEOUT - 1);

  linkState_t state, stateNext;
  logic rxMode;
  logic [TW-1:0] ackTimer;
  logic shiftEnd, ackBack, ackExpire;

  assign shiftEnd  = (state == ST_SHIFT) && evt.clkRise && evt.lastBit;
  assign ackBack   = (state == ST_WAITACK) && evt.ackHigh;
  assign ackExpire = (state == ST_WAITACK) && !evt.ackHigh && (ackTimer == TIMER_LAST);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    cmd = '0;
    cmd.dirRx = dir;
    case (state)
      ST_IDLE:  cmd.setup = start;
      ST_SHIFT: begin
        cmd.shiftIn  = evt.clkRise & rxMode;
        cmd.shiftOut = evt.clkFall & ~rxMode;
        cmd.countBit = evt.clkRise;
        cmd.capture  = shiftEnd & rxMode;
        cmd.endShift = shiftEnd;
      end
      default: ;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (start) stateNext = ST_SETUP;
      ST_SETUP:   stateNext = ST_SHIFT;
      ST_SHIFT:   if (shiftEnd) stateNext = ST_WAITACK;
      ST_WAITACK: if (ackBack || ackExpire) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      rxMode       <= 1'b0;
      reqN         <= 1'b1;
      done         <= 1'b0;
      timeoutErr   <= 1'b0;
      ackEarlyWarn <= 1'b0;
      ackTimer     <= '0;
    end else begin
      state <= stateNext;
      done  <= ackBack || ackExpire;
      if (cmd.setup) begin
        rxMode       <= dir;
        timeoutErr   <= 1'b0;
        ackEarlyWarn <= 1'b0;
      end
      if (state == ST_SETUP) reqN <= 1'b0;
      if (shiftEnd) begin
        reqN     <= 1'b1;
        ackTimer <= '0;
        if (evt.ackHigh) ackEarlyWarn <= 1'b1;
      end else if (state == ST_WAITACK && !evt.ackHigh) begin
        ackTimer <= ackTimer + 1'b1;
      end
      if (ackExpire) timeoutErr <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_REQ_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reqN); // R6

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeoutErr) |-> done); // R7

  AST_REQ_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reqN) |-> $past(cmd.setup, 2)); // R2

  AST_SHIFT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> reqN); // R10

endmodule

// File: rtl/hs_shift_link.sv
module hs_shift_link
  import hslink_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS = 8,
  parameter int ACK_TIMEOUT = 1600000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 dir,
  input  logic [BYTE_BITS-1:0] txByte,
  output logic                 done,
  output logic                 busy,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 timeoutErr,
  output logic                 ackEarlyWarn,
  input  logic                 shiftClk,
  input  logic                 shiftDataIn,
  output logic                 shiftDataOut,
  output logic                 shiftOutEn,
  output logic                 reqN,
  input  logic                 ackN
);

  linkCmd_t cmd;
  linkEvt_t evt;

  hslink_ctrl #(
    .ACK_TIMEOUT(ACK_TIMEOUT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dir         (dir),
    .evt         (evt),
    .cmd         (cmd),
    .reqN        (reqN),
    .done        (done),
    .busy        (busy),
    .timeoutErr  (timeoutErr),
    .ackEarlyWarn(ackEarlyWarn)
  );

  hslink_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_BITS  (BYTE_BITS)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .txByte      (txByte),
    .shiftClk    (shiftClk),
    .shiftDataIn (shiftDataIn),
    .ackN        (ackN),
    .evt         (evt),
    .rxByte      (rxByte),
    .shiftDataOut(shiftDataOut),
    .shiftOutEn  (shiftOutEn)
  );

endmodule

// File: tb/tb_hs_shift_link.sv
`timescale 1ns/1ps
module tb_hs_shift_link;

  localparam int TOUT = 64;
  localparam int HALF = 5;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0;
  logic [7:0] txByte = '0;
  logic shiftClk = 1'b0, shiftDataIn = 1'b0, ackN = 1'b1;
  logic done, busy, timeoutErr, ackEarlyWarn, shiftDataOut, shiftOutEn, reqN;
  logic [7:0] rxByte;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  logic [7:0] expRx = 8'h00;

  always #10 clk = ~clk;

  hs_shift_link #(
    .SYNC_STAGES(2),
    .BYTE_BITS(8),
    .ACK_TIMEOUT(TOUT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .txByte(txByte),
    .done(done), .busy(busy), .rxByte(rxByte), .timeoutErr(timeoutErr),
    .ackEarlyWarn(ackEarlyWarn), .shiftClk(shiftClk), .shiftDataIn(shiftDataIn),
    .shiftDataOut(shiftDataOut), .shiftOutEn(shiftOutEn), .reqN(reqN), .ackN(ackN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  // mode: 0 normal ack return, 1 ack already high, 2 ack never returns
  task automatic xfer(input logic rxDir, input logic [7:0] hostB, input logic [7:0] microB,
                      input int mode, input bit poke);
    logic [7:0] seen;
    int n;
    seen = '0;
    @(negedge clk);
    start = 1'b1; dir = rxDir; txByte = hostB;
    @(negedge clk);
    start = 1'b0;
    chk(shiftOutEn == !rxDir, "R2 dir applied", shiftOutEn, !rxDir);
    chk(reqN == 1'b1 && busy == 1'b1, "R2 req still high at setup", {reqN, busy}, 2'b11);
    chk(timeoutErr == 1'b0 && ackEarlyWarn == 1'b0, "R7 R8 flags cleared by start",
        {timeoutErr, ackEarlyWarn}, 0);
    if (!rxDir) chk(shiftDataOut == hostB[7], "R3 first bit", shiftDataOut, hostB[7]);
    else        chk(shiftDataOut == 1'b1, "R4 line idle high", shiftDataOut, 1);
    @(negedge clk);
    chk(reqN == 1'b0, "R2 req asserted", reqN, 0);
    if (mode != 1) ackN = 1'b0;
    if (poke) begin
      start = 1'b1; dir = !rxDir; txByte = ~hostB;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chk(shiftOutEn == !rxDir, "R9 start ignored while busy", shiftOutEn, !rxDir);
    end
    for (int i = 7; i >= 0; i--) begin
      shiftDataIn = microB[i];
      repeat (HALF) @(negedge clk);
      seen[i] = shiftDataOut;
      shiftClk = 1'b1;
      if (i != 0) begin
        repeat (HALF) @(negedge clk);
        shiftClk = 1'b0;
      end else begin
        n = 0;
        do begin
          @(negedge clk);
          n++;
        end while (!reqN && n < 20);
        chk(n == LAT, "R5 req release latency", n, LAT);
      end
    end
    shiftClk = 1'b0;
    if (rxDir) begin
      expRx = microB;
      chk(rxByte == microB, "R4 received byte", rxByte, microB);
    end else begin
      chk(seen == hostB, "R3 transmitted byte", seen, hostB);
      chk(rxByte == expRx, "R4 rxByte kept on transmit", rxByte, expRx);
    end
    chk(shiftOutEn == 1'b0, "R3 line released", shiftOutEn, 0);
    n = 0;
    if (mode == 0) begin
      repeat (LAT) @(negedge clk);
      chk(done == 1'b0 && busy == 1'b1, "R6 wait for ack", {done, busy}, 2'b01);
      ackN = 1'b1;
      do begin @(negedge clk); n++; end while (!done && n < 20);
      chk(n == LAT, "R6 done latency", n, LAT);
      chk(timeoutErr == 1'b0 && ackEarlyWarn == 1'b0, "R6 clean status",
          {timeoutErr, ackEarlyWarn}, 0);
    end else if (mode == 1) begin
      do begin @(negedge clk); n++; end while (!done && n < 20);
      chk(n == 1, "R8 done after early ack", n, 1);
      chk(ackEarlyWarn == 1'b1 && timeoutErr == 1'b0, "R8 early warning",
          {timeoutErr, ackEarlyWarn}, 1);
    end else begin
      do begin @(negedge clk); n++; end while (!done && n < TOUT + 20);
      chk(n == TOUT, "R7 timeout latency", n, TOUT);
      chk(timeoutErr == 1'b1, "R7 timeout flag", timeoutErr, 1);
      ackN = 1'b1;
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 single done pulse", {done, busy}, 0);
    if (mode == 2) begin
      repeat (4) @(negedge clk);
      chk(timeoutErr == 1'b1, "R7 timeout flag held", timeoutErr, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reqN == 1'b1 && shiftOutEn == 1'b0, "R1 reset lines", {reqN, shiftOutEn}, 2'b10);
    chk(done == 0 && busy == 0 && timeoutErr == 0 && ackEarlyWarn == 0,
        "R1 reset status", {done, busy, timeoutErr, ackEarlyWarn}, 0);
    chk(rxByte == 8'h00, "R1 reset rxByte", rxByte, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int b = 0; b < 256; b++) xfer(1'b0, 8'(b), ~8'(b), 0, 1'b0);
    for (int b = 0; b < 256; b++) xfer(1'b1, 8'(b ^ 8'h5a), 8'(b), 0, 1'b0);

    // R10: clock activity while idle
    for (int k = 0; k < 3; k++) begin
      shiftDataIn = k[0];
      repeat (HALF) @(negedge clk); shiftClk = 1'b1;
      repeat (HALF) @(negedge clk); shiftClk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    chk(reqN == 1'b1 && busy == 1'b0 && shiftDataOut == 1'b1, "R10 idle clock ignored",
        {reqN, busy, shiftDataOut}, 3'b101);
    chk(rxByte == expRx, "R10 rxByte kept", rxByte, expRx);

    xfer(1'b0, 8'hc3, 8'h00, 0, 1'b1);
    xfer(1'b1, 8'h00, 8'h96, 0, 1'b1);
    xfer(1'b0, 8'h81, 8'h7e, 1, 1'b0);
    xfer(1'b1, 8'h00, 8'h3c, 2, 1'b0);
    xfer(1'b0, 8'h18, 8'hff, 0, 1'b0);
    summary();
  end

endmodule